// File: doc/BRIEF.md
# DMA Two-Level Address Generator

This block produces the source and destination addresses for one DMA channel. The channel moves a block as a number of frames, and each frame holds a number of elements. Two index words, both writable through a small register port, give the address offsets. The element index word holds the step applied between elements of the same frame. The frame index word holds the step applied when a frame ends. Each word has its own source offset and its own destination offset, so the two addresses can walk different strides.

A `start` pulse loads the start addresses, the element count and the frame count, and moves the controller from `ST_IDLE` to `ST_RUN`. While the controller is in `ST_RUN`, each pulse on `xfer` is one finished element transfer and advances the state as follows:

- On an ordinary element the controller issues `STEP_ELEM`.
- On the last element of a frame that is not the last frame it issues `STEP_FRAME`.
- On the last element of the last frame it takes the transition `RUN->IDLE` and pulses `done`.

A `start` seen in `ST_RUN` takes the transition `RUN->RUN` and restarts the block. A `start` seen in `ST_IDLE` takes `IDLE->RUN`. The data mover, request arbitration and interrupts are outside this block.

Top module: `dma_addr_gen`

## Requirements
- R1: `reg_sel`=0 selects the element index word and `reg_sel`=1 selects the frame index word. In each word, bits 28:16 hold the 13-bit destination offset and bits 12:0 hold the 13-bit source offset. A privileged write to a word is returned on `reg_rdata` while that word is selected, starting in the cycle after the write.
- R2: Bits 31:29 and 15:13 of both words always read 0. Writing to these bits has no effect.
- R3: A write with `priv`=0 leaves both words unchanged.
- R4: One cycle after `start`, `src_addr`/`dst_addr` equal `start_src`/`start_dst`, `elem_left`/`frame_left` equal `elem_count`/`frame_count`, and `active`=1.
- R5: An `xfer` with `elem_left`>1 adds the zero-extended source element offset to `src_addr` and the destination element offset to `dst_addr`. It also decrements `elem_left` and leaves `frame_left` unchanged.
- R6: An `xfer` with `elem_left`=1 and `frame_left`>1 adds the frame offsets to the addresses instead of the element offsets. It reloads `elem_left` with the loaded element count and decrements `frame_left`.
- R7: An `xfer` with `elem_left`=1 and `frame_left`=1 raises `done` for exactly one cycle and clears `active`. The addresses and counters keep their values.
- R8: An `xfer` while `active`=0 changes no output.
- R9: Synchronous reset clears `active`, `done`, both counters, both addresses and both index words.
- R10: A `start` while a block is active restarts it from the new inputs. When `start` and `xfer` arrive in the same cycle, `start` wins.
- R11: Address addition wraps modulo 2^32.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| priv | input | 1 | Privilege qualifier for register writes |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 1 | Index word select (0 element, 1 frame) |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data of the selected word |
| start | input | 1 | Block start pulse |
| start_src | input | 32 | Source start address |
| start_dst | input | 32 | Destination start address |
| elem_count | input | 16 | Elements per frame |
| frame_count | input | 16 | Frames per block |
| xfer | input | 1 | Element transfer completed strobe |
| src_addr | output | 32 | Current source address |
| dst_addr | output | 32 | Current destination address |
| elem_left | output | 16 | Elements left in the current frame |
| frame_left | output | 16 | Frames left in the block |
| active | output | 1 | Block in progress |
| done | output | 1 | One-cycle pulse at block end |

## Verification
The checker assumes that `start` always carries nonzero element and frame counts. With a zero count, the decrement properties would describe an underflow that this design never defines. The checker also assumes that `reg_sel` is steady across a rejected write whenever the read-back stability is judged; the property is written so that it applies only in that case. The stimulus loads only counts of 1 or more. It changes `reg_sel` only between write pulses, never during one.

// File: rtl/dma_ag_pkg.sv
package dma_ag_pkg;
    typedef enum logic {
        ST_IDLE,
        ST_RUN
    } ag_state_e;

    typedef enum logic [1:0] {
        STEP_NONE,
        STEP_ELEM,
        STEP_FRAME
    } ag_step_e;
endpackage

// File: rtl/dma_ag_idx_regs.sv
module dma_ag_idx_regs #(
    parameter int WORD_W  = 32,
    parameter int OFF_W   = 13,
    parameter int DST_LSB = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              priv,
    input  logic              we,
    input  logic              sel,
    input  logic [WORD_W-1:0] wdata,
    output logic [OFF_W-1:0]  src_elem,
    output logic [OFF_W-1:0]  dst_elem,
    output logic [OFF_W-1:0]  src_frame,
    output logic [OFF_W-1:0]  dst_frame,
    output logic [WORD_W-1:0] rdata
);
    localparam int NWORDS = 2;

    logic [OFF_W-1:0] src_q [NWORDS];
    logic [OFF_W-1:0] dst_q [NWORDS];

    for (genvar g = 0; g < NWORDS; g++) begin : g_word
        always_ff @(posedge clk) begin
            if (rst) begin
                src_q[g] <= '0;
                dst_q[g] <= '0;
            end else if (we && priv && (sel == 1'(g))) begin
                src_q[g] <= wdata[OFF_W-1:0];
                dst_q[g] <= wdata[DST_LSB +: OFF_W];
            end
        end
    end

    assign src_elem  = src_q[0];
    assign dst_elem  = dst_q[0];
    assign src_frame = src_q[1];
    assign dst_frame = dst_q[1];

    always_comb begin
        rdata                    = '0;
        rdata[OFF_W-1:0]         = src_q[sel];
        rdata[DST_LSB +: OFF_W]  = dst_q[sel];
    end
endmodule

// File: rtl/dma_ag_ctrl.sv
module dma_ag_ctrl
    import dma_ag_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [CNT_W-1:0] elem_count,
    input  logic [CNT_W-1:0] frame_count,
    input  logic             xfer,
    output ag_step_e         step,
    output logic [CNT_W-1:0] elem_left,
    output logic [CNT_W-1:0] frame_left,
    output logic             active,
    output logic             done
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    ag_state_e        state_q, state_d;
    logic [CNT_W-1:0] elem_q, frame_q, reload_q;
    logic             done_q, last;

    always_comb begin
        step = STEP_NONE;
        last = 1'b0;
        if (state_q == ST_RUN && xfer && !start) begin
            if (elem_q == ONE) begin
                if (frame_q == ONE) last = 1'b1;
                else                step = STEP_FRAME;
            end else begin
                step = STEP_ELEM;
            end
        end
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (start) state_d = ST_RUN;
            ST_RUN:  if (start) state_d = ST_RUN;
                     else if (last) state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_IDLE;
        else     state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            elem_q   <= '0;
            frame_q  <= '0;
            reload_q <= '0;
            done_q   <= 1'b0;
        end else begin
            done_q <= last;
            if (start) begin
                elem_q   <= elem_count;
                frame_q  <= frame_count;
                reload_q <= elem_count;
            end else begin
                unique case (step)
                    STEP_ELEM:  elem_q <= elem_q - ONE;
                    STEP_FRAME: begin
                        elem_q  <= reload_q;
                        frame_q <= frame_q - ONE;
                    end
                    default: ;
                endcase
            end
        end
    end

    assign elem_left  = elem_q;
    assign frame_left = frame_q;
    assign active     = (state_q == ST_RUN);
    assign done       = done_q;
endmodule

// File: rtl/dma_ag_addr_lane.sv
module dma_ag_addr_lane
    import dma_ag_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int OFF_W  = 13
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [ADDR_W-1:0] start_addr,
    input  ag_step_e          step,
    input  logic [OFF_W-1:0]  off_elem,
    input  logic [OFF_W-1:0]  off_frame,
    output logic [ADDR_W-1:0] addr
);
    localparam int PAD = ADDR_W - OFF_W;

    logic [ADDR_W-1:0] addr_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q <= '0;
        end else if (load) begin
            addr_q <= start_addr;
        end else begin
            unique case (step)
                STEP_ELEM:  addr_q <= addr_q + {{PAD{1'b0}}, off_elem};
                STEP_FRAME: addr_q <= addr_q + {{PAD{1'b0}}, off_frame};
                default: ;
            endcase
        end
    end

    assign addr = addr_q;
endmodule

// File: rtl/dma_addr_gen.sv
module dma_addr_gen
    import dma_ag_pkg::*;
#(
    parameter int ADDR_W  = 32,
    parameter int WORD_W  = 32,
    parameter int OFF_W   = 13,
    parameter int DST_LSB = 16,
    parameter int CNT_W   = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              priv,
    input  logic              reg_we,
    input  logic              reg_sel,
    input  logic [WORD_W-1:0] reg_wdata,
    output logic [WORD_W-1:0] reg_rdata,
    input  logic              start,
    input  logic [ADDR_W-1:0] start_src,
    input  logic [ADDR_W-1:0] start_dst,
    input  logic [CNT_W-1:0]  elem_count,
    input  logic [CNT_W-1:0]  frame_count,
    input  logic              xfer,
    output logic [ADDR_W-1:0] src_addr,
    output logic [ADDR_W-1:0] dst_addr,
    output logic [CNT_W-1:0]  elem_left,
    output logic [CNT_W-1:0]  frame_left,
    output logic              active,
    output logic              done
);
    localparam int NLANES = 2;

    logic [OFF_W-1:0]  src_e, dst_e, src_f, dst_f;
    ag_step_e          step;
    logic [ADDR_W-1:0] lane_start [NLANES];
    logic [OFF_W-1:0]  lane_oe    [NLANES];
    logic [OFF_W-1:0]  lane_of    [NLANES];
    logic [ADDR_W-1:0] lane_addr  [NLANES];

    dma_ag_idx_regs #(.WORD_W(WORD_W), .OFF_W(OFF_W), .DST_LSB(DST_LSB)) u_regs (
        .clk(clk), .rst(rst), .priv(priv), .we(reg_we), .sel(reg_sel),
        .wdata(reg_wdata), .src_elem(src_e), .dst_elem(dst_e),
        .src_frame(src_f), .dst_frame(dst_f), .rdata(reg_rdata)
    );

    dma_ag_ctrl #(.CNT_W(CNT_W)) u_ctrl (
        .clk(clk), .rst(rst), .start(start), .elem_count(elem_count),
        .frame_count(frame_count), .xfer(xfer), .step(step),
        .elem_left(elem_left), .frame_left(frame_left),
        .active(active), .done(done)
    );

    assign lane_start[0] = start_src;
    assign lane_start[1] = start_dst;
    assign lane_oe[0]    = src_e;
    assign lane_oe[1]    = dst_e;
    assign lane_of[0]    = src_f;
    assign lane_of[1]    = dst_f;

    for (genvar l = 0; l < NLANES; l++) begin : g_lane
        dma_ag_addr_lane #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) u_lane (
            .clk(clk), .rst(rst), .load(start), .start_addr(lane_start[l]),
            .step(step), .off_elem(lane_oe[l]), .off_frame(lane_of[l]),
            .addr(lane_addr[l])
        );
    end

    assign src_addr = lane_addr[0];
    assign dst_addr = lane_addr[1];
endmodule

// File: rtl/dma_addr_gen_chk.sv
module dma_addr_gen_chk #(
    parameter int ADDR_W = 32,
    parameter int WORD_W = 32,
    parameter int CNT_W  = 16
) (
    input logic              clk,
    input logic              rst,
    input logic              priv,
    input logic              reg_we,
    input logic              reg_sel,
    input logic [WORD_W-1:0] reg_rdata,
    input logic              start,
    input logic [ADDR_W-1:0] start_src,
    input logic [ADDR_W-1:0] start_dst,
    input logic              xfer,
    input logic [ADDR_W-1:0] src_addr,
    input logic [ADDR_W-1:0] dst_addr,
    input logic [CNT_W-1:0]  elem_left,
    input logic [CNT_W-1:0]  frame_left,
    input logic              active,
    input logic              done
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    // R2
    rsvd_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (reg_rdata[31:29] == 3'b0) && (reg_rdata[15:13] == 3'b0));

    // R3
    unpriv_write_chk: assert property (@(posedge clk) disable iff (rst)
        (reg_we && !priv) |=> ((reg_sel != $past(reg_sel)) || $stable(reg_rdata)));

    // R4
    start_load_chk: assert property (@(posedge clk) disable iff (rst)
        start |=> (active && src_addr == $past(start_src) && dst_addr == $past(start_dst)));

    // R5
    elem_step_chk: assert property (@(posedge clk) disable iff (rst)
        (active && xfer && !start && elem_left > ONE)
        |=> (elem_left == $past(elem_left) - ONE && $stable(frame_left)));

    // R6
    frame_step_chk: assert property (@(posedge clk) disable iff (rst)
        (active && xfer && !start && elem_left == ONE && frame_left > ONE)
        |=> (frame_left == $past(frame_left) - ONE));

    // R7
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R7
    done_idle_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> (!active && $stable(src_addr) && $stable(dst_addr)));

    // R8
    idle_xfer_chk: assert property (@(posedge clk) disable iff (rst)
        (!active && !start) |=> ($stable(src_addr) && $stable(dst_addr) && !active && !done));
endmodule

bind dma_addr_gen dma_addr_gen_chk #(.ADDR_W(ADDR_W), .WORD_W(WORD_W), .CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst(rst), .priv(priv), .reg_we(reg_we), .reg_sel(reg_sel),
    .reg_rdata(reg_rdata), .start(start), .start_src(start_src),
    .start_dst(start_dst), .xfer(xfer), .src_addr(src_addr),
    .dst_addr(dst_addr), .elem_left(elem_left), .frame_left(frame_left),
    .active(active), .done(done)
);

// File: tb/sim_dma_addr_gen.sv
module sim_dma_addr_gen;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        priv = 1'b0, reg_we = 1'b0, reg_sel = 1'b0;
    logic [31:0] reg_wdata = '0, reg_rdata;
    logic        start = 1'b0, xfer = 1'b0;
    logic [31:0] start_src = '0, start_dst = '0, src_addr, dst_addr;
    logic [15:0] elem_count = '0, frame_count = '0, elem_left, frame_left;
    logic        active, done;

    int errors = 0;
    int checks = 0;

    always #2 clk = ~clk;

    dma_addr_gen u0 (
        .clk(clk), .rst(rst), .priv(priv), .reg_we(reg_we), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .start(start),
        .start_src(start_src), .start_dst(start_dst), .elem_count(elem_count),
        .frame_count(frame_count), .xfer(xfer), .src_addr(src_addr),
        .dst_addr(dst_addr), .elem_left(elem_left), .frame_left(frame_left),
        .active(active), .done(done)
    );

    // {priv, sel, wdata, expected read-back of sel}
    localparam logic [65:0] VEC [6] = '{
        {1'b1, 1'b0, 32'hFFFF_FFFF, 32'h1FFF_1FFF},   // R1 R2
        {1'b1, 1'b1, 32'h0123_0456, 32'h0123_0456},   // R1
        {1'b0, 1'b0, 32'h0000_0000, 32'h1FFF_1FFF},   // R3
        {1'b1, 1'b0, 32'hE004_E008, 32'h0004_0008},   // R2
        {1'b0, 1'b1, 32'hFFFF_FFFF, 32'h0123_0456},   // R3
        {1'b1, 1'b1, 32'h0020_0100, 32'h0020_0100}    // R1
    };

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic cyc();
        @(posedge clk); #1;
    endtask

    task automatic wr(input logic p, input logic s, input logic [31:0] d);
        @(negedge clk); priv = p; reg_sel = s; reg_wdata = d; reg_we = 1'b1;
        cyc(); reg_we = 1'b0; priv = 1'b0;
    endtask

    task automatic go(input logic [31:0] s, input logic [31:0] d, input logic [15:0] e, input logic [15:0] f, input logic with_xfer);
        @(negedge clk); start_src = s; start_dst = d; elem_count = e; frame_count = f;
        start = 1'b1; xfer = with_xfer;
        cyc(); start = 1'b0; xfer = 1'b0;
    endtask

    task automatic step();
        @(negedge clk); xfer = 1'b1;
        cyc(); xfer = 1'b0;
    endtask

    task automatic expect_state(input string req, input logic [31:0] s, input logic [31:0] d, input logic [15:0] e, input logic [15:0] f);
        chk({req, " src"}, src_addr, s);
        chk({req, " dst"}, dst_addr, d);
        chk({req, " elem"}, {16'h0, elem_left}, {16'h0, e});
        chk({req, " frame"}, {16'h0, frame_left}, {16'h0, f});
    endtask

    initial begin
        #400000;
        errors++; checks++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        cyc(); cyc(); rst = 1'b0; #1;
        // R9 reset state
        expect_state("R9", 32'h0, 32'h0, 16'h0, 16'h0);
        chk("R9 active", {31'h0, active}, 32'h0);
        chk("R9 done", {31'h0, done}, 32'h0);
        chk("R9 regs", reg_rdata, 32'h0);

        for (int i = 0; i < 6; i++) begin
            wr(VEC[i][65], VEC[i][64], VEC[i][63:32]);
            reg_sel = VEC[i][64]; #1;
            chk("R1/R2/R3 vector", reg_rdata, VEC[i][31:0]);
        end
        reg_sel = 1'b0; #1;
        chk("R3 elem word kept", reg_rdata, 32'h0004_0008);

        // R8 idle strobe ignored
        step();
        expect_state("R8", 32'h0, 32'h0, 16'h0, 16'h0);
        chk("R8 active", {31'h0, active}, 32'h0);

        // R4 start: 3 elements x 2 frames
        go(32'h1000, 32'h2000, 16'd3, 16'd2, 1'b0);
        expect_state("R4", 32'h1000, 32'h2000, 16'd3, 16'd2);
        chk("R4 active", {31'h0, active}, 32'h1);
        step(); expect_state("R5 e1", 32'h1008, 32'h2004, 16'd2, 16'd2);
        step(); expect_state("R5 e2", 32'h1010, 32'h2008, 16'd1, 16'd2);
        step(); expect_state("R6", 32'h1110, 32'h2028, 16'd3, 16'd1);
        step(); expect_state("R5 e4", 32'h1118, 32'h202C, 16'd2, 16'd1);
        step(); expect_state("R5 e5", 32'h1120, 32'h2030, 16'd1, 16'd1);
        step();
        expect_state("R7 hold", 32'h1120, 32'h2030, 16'd1, 16'd1);
        chk("R7 done", {31'h0, done}, 32'h1);
        chk("R7 active", {31'h0, active}, 32'h0);
        cyc();
        chk("R7 done one cycle", {31'h0, done}, 32'h0);
        step();
        expect_state("R8 after end", 32'h1120, 32'h2030, 16'd1, 16'd1);

        // R11 wraparound
        go(32'hFFFF_FFFC, 32'hFFFF_FFFE, 16'd2, 16'd1, 1'b0);
        step(); expect_state("R11", 32'h0000_0004, 32'h0000_0002, 16'd1, 16'd1);

        // R10 restart while active, start wins over simultaneous xfer
        go(32'h0000_4000, 32'h0000_5000, 16'd4, 16'd3, 1'b1);
        expect_state("R10", 32'h4000, 32'h5000, 16'd4, 16'd3);
        chk("R10 active", {31'h0, active}, 32'h1);

        // R6 with single-element frames
        go(32'h0, 32'h0, 16'd1, 16'd2, 1'b0);
        step(); expect_state("R6 single", 32'h0100, 32'h0020, 16'd1, 16'd1);

        // R9 reset mid-block
        @(negedge clk); rst = 1'b1; cyc(); rst = 1'b0; #1;
        expect_state("R9 mid", 32'h0, 32'h0, 16'h0, 16'h0);
        chk("R9 mid active", {31'h0, active}, 32'h0);
        chk("R9 mid regs", reg_rdata, 32'h0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule